// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Inserter

This block sits in the transmit path of a T1 framer. It works on the bit-serial system-side stream, one bit per clock. A frame-sync pulse marks the framing bit position, and a frame number from the surrounding framer gives each frame's place in the multiframe. In the frames that carry signaling, the block replaces the least significant bit of every time slot with the A, B, C or D signaling bit that belongs to that slot. It passes every other bit through, registered, with one cycle of delay.

Signaling comes from two sources. The first is an external serial signaling line that is time-slot aligned with the data. It is sampled in bits 5 to 8 of every slot during the last frame of a multiframe, and those values are used for the whole next multiframe. The second is an internal per-slot source that takes priority when enabled. The framing bit position of the output is taken from the signaling line.

Per-slot masks give clear-channel slots, where no signaling is inserted, and idle slots, where the data is replaced by an idle code. Two control bits refine these: one forces robbed bits to one in clear channels, and one keeps robbed bits intact in idle slots.

Top module: `t1rb_inserter`

## Requirements
- R1: While reset is held (rst_n low), data_out and fsync_out are 0.
- R2: Every output bit appears on the clock after its input bit, and fsync_out is fsync delayed by one clock.
- R3: In a non-idle slot, every bit except a robbed bit is output unchanged from data_in.
- R4: fsync high marks the framing bit, and frame_idx is sampled with it for the whole frame. At the framing bit, data_out carries the value of sig_in in that cycle.
- R5: Robbed bits are bit 8 (the last bit) of every slot. With esf_mode=0, they are in frames 5 (A) and 11 (B), counting frame_idx from 0. With esf_mode=1, they are in frames 5, 11, 17 and 23 (A, B, C, D).
- R6: sig_in is captured in bit 5 as A, bit 6 as B, bit 7 as C and bit 8 as D of each slot. Capture happens only in the last frame of the multiframe (frame_idx 11 when esf_mode=0, 23 when esf_mode=1). Bits 1 to 4 and all other frames are ignored. The captured set replaces the active set at the fsync where frame_idx is 0, and the active set is 0 after reset.
- R7: When int_sig_en[s] is 1, the robbed bits of slot s come from int_sig_abcd[4s+3:4s] (A in bit 4s+3, D in bit 4s) and not from the external input.
- R8: In a slot with clear_mask[s]=1, a robbed bit position is output as 1 when force_ones_clear=1. Otherwise it keeps the underlying slot bit.
- R9: In a slot with idle_mask[s]=1, bit k of the slot (k=1 first) is output as idle_code[SLOT_BITS-k]. When idle_keep_sig=0, this includes the robbed bits.
- R10: When idle_keep_sig=1, the robbed bits of idle slots still follow R5 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High on the framing bit of each frame |
| frame_idx | input | 5 | Frame number in the multiframe, sampled with fsync |
| data_in | input | 1 | Serial transmit data |
| sig_in | input | 1 | Serial external signaling and framing bit |
| esf_mode | input | 1 | 1: 24-frame multiframe with four signaling bits; 0: 12-frame with two |
| int_sig_en | input | NUM_SLOTS | Per-slot select of internal signaling |
| int_sig_abcd | input | 4*NUM_SLOTS | Internal A/B/C/D bits, four per slot |
| clear_mask | input | NUM_SLOTS | Per-slot clear-channel mask |
| force_ones_clear | input | 1 | Force robbed bits to 1 in clear channels |
| idle_mask | input | NUM_SLOTS | Per-slot idle mask |
| idle_keep_sig | input | 1 | Keep robbed bits in idle slots |
| idle_code | input | SLOT_BITS | Idle pattern, first bit in the MSB |
| data_out | output | 1 | Serial output stream |
| fsync_out | output | 1 | Frame sync aligned with data_out |

## Verification
The bench drives random values on sig_in in every bit and every frame. A design that captured outside bits 5 to 8 of the last frame, or that updated its active set before the multiframe boundary, would put wrong robbed bits into the next multiframe. Multiframes alternate between the two modes and use changing clear, idle and internal masks with both force and keep settings. This catches a wrong A/B/C/D order, a wrong frame set in either mode, and a wrong priority between idle code, clear channel and internal signaling. The framing-bit substitution and the one-cycle latency are checked on every bit, so a shifted pipeline shows up at once.

// File: rtl/t1rb_pkg.sv
package t1rb_pkg;

    localparam int SIG_BITS  = 4;
    localparam int FRAME_W   = 5;

    typedef logic [SIG_BITS-1:0] abcd_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] sel;
    } sig_frame_t;

    // which signaling bit (0 = A) a frame carries
    function automatic sig_frame_t decode_frame(input logic [FRAME_W-1:0] idx, input logic esf);
        sig_frame_t r;
        r.hit = 1'b0;
        r.sel = 2'd0;
        case (idx)
            5'd5:    begin r.hit = 1'b1; r.sel = 2'd0; end
            5'd11:   begin r.hit = 1'b1; r.sel = 2'd1; end
            5'd17:   begin r.hit = esf;  r.sel = 2'd2; end
            5'd23:   begin r.hit = esf;  r.sel = 2'd3; end
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic is_last_frame(input logic [FRAME_W-1:0] idx, input logic esf);
        return esf ? (idx == 5'd23) : (idx == 5'd11);
    endfunction

endpackage

// File: rtl/t1rb_position.sv
module t1rb_position
    import t1rb_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int BIT_W  = $clog2(SLOT_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic [FRAME_W-1:0] frame_idx,
    output logic               cur_is_f,
    output logic [SLOT_W-1:0]  cur_slot,
    output logic [BIT_W-1:0]   cur_bit,
    output logic [FRAME_W-1:0] cur_frame
);

    typedef struct packed {
        logic               at_f;
        logic [SLOT_W-1:0]  slot;
        logic [BIT_W-1:0]   bitn;
        logic [FRAME_W-1:0] frame;
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        cur_is_f  = fsync | st_q.at_f;
        cur_slot  = st_q.slot;
        cur_bit   = st_q.bitn;
        cur_frame = fsync ? frame_idx : st_q.frame;

        st_d       = st_q;
        st_d.frame = cur_frame;
        if (cur_is_f) begin
            st_d.at_f = 1'b0;
            st_d.slot = '0;
            st_d.bitn = '0;
        end else if (st_q.bitn == BIT_W'(SLOT_BITS - 1)) begin
            st_d.bitn = '0;
            if (st_q.slot == SLOT_W'(NUM_SLOTS - 1)) begin
                st_d.slot = '0;
                st_d.at_f = 1'b1;
            end else begin
                st_d.slot = st_q.slot + SLOT_W'(1);
            end
        end else begin
            st_d.bitn = st_q.bitn + BIT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{at_f: 1'b1, slot: '0, bitn: '0, frame: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/t1rb_sig_store.sv
module t1rb_sig_store
    import t1rb_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int BIT_W     = $clog2(SLOT_BITS),
    localparam int SIG_FIRST = SLOT_BITS - SIG_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fsync,
    input  logic                    cur_is_f,
    input  logic [SLOT_W-1:0]       cur_slot,
    input  logic [BIT_W-1:0]        cur_bit,
    input  logic [FRAME_W-1:0]      cur_frame,
    input  logic                    esf_mode,
    input  logic                    sig_in,
    output abcd_t [NUM_SLOTS-1:0]   shadow,
    output abcd_t [NUM_SLOTS-1:0]   active
);

    typedef struct packed {
        abcd_t [NUM_SLOTS-1:0] shadow;
        abcd_t [NUM_SLOTS-1:0] active;
    } store_t;

    store_t     st_d, st_q;
    logic [1:0] pick;

    always_comb begin
        st_d = st_q;
        // first sampled bit is A, held in the nibble MSB
        pick = 2'(SIG_BITS - 1) - 2'(cur_bit - BIT_W'(SIG_FIRST));
        if (fsync && cur_frame == '0) begin
            st_d.active = st_q.shadow;
        end
        if (!cur_is_f && is_last_frame(cur_frame, esf_mode) &&
            cur_bit >= BIT_W'(SIG_FIRST)) begin
            st_d.shadow[cur_slot][pick] = sig_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow = st_q.shadow;
    assign active = st_q.active;

endmodule

// File: rtl/t1rb_bit_select.sv
module t1rb_bit_select
    import t1rb_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int BIT_W  = $clog2(SLOT_BITS)
) (
    input  logic                  data_in,
    input  logic                  sig_in,
    input  logic                  cur_is_f,
    input  logic [SLOT_W-1:0]     cur_slot,
    input  logic [BIT_W-1:0]      cur_bit,
    input  logic [FRAME_W-1:0]    cur_frame,
    input  logic                  esf_mode,
    input  abcd_t [NUM_SLOTS-1:0] active,
    input  logic [NUM_SLOTS-1:0]  int_sig_en,
    input  abcd_t [NUM_SLOTS-1:0] int_sig,
    input  logic [NUM_SLOTS-1:0]  clear_mask,
    input  logic                  force_ones_clear,
    input  logic [NUM_SLOTS-1:0]  idle_mask,
    input  logic                  idle_keep_sig,
    input  logic [SLOT_BITS-1:0]  idle_code,
    output logic                  bit_out
);

    sig_frame_t           sf;
    logic                 at_lsb, idle, robbed, base, sig_bit;
    logic [SLOT_BITS-1:0] idle_sh;
    abcd_t                ext_nib, int_nib;

    always_comb begin
        sf      = decode_frame(cur_frame, esf_mode);
        at_lsb  = (cur_bit == BIT_W'(SLOT_BITS - 1));
        idle    = idle_mask[cur_slot];
        idle_sh = idle_code << cur_bit;
        base    = idle ? idle_sh[SLOT_BITS-1] : data_in;
        robbed  = sf.hit && at_lsb && (!idle || idle_keep_sig);
        ext_nib = active[cur_slot] << sf.sel;
        int_nib = int_sig[cur_slot] << sf.sel;
        sig_bit = int_sig_en[cur_slot] ? int_nib[SIG_BITS-1] : ext_nib[SIG_BITS-1];

        if (cur_is_f) begin
            bit_out = sig_in;
        end else if (robbed) begin
            if (clear_mask[cur_slot]) begin
                bit_out = force_ones_clear ? 1'b1 : base;
            end else begin
                bit_out = sig_bit;
            end
        end else begin
            bit_out = base;
        end
    end

endmodule

// File: rtl/t1rb_inserter.sv
module t1rb_inserter
    import t1rb_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int BIT_W  = $clog2(SLOT_BITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fsync,
    input  logic [4:0]                    frame_idx,
    input  logic                          data_in,
    input  logic                          sig_in,
    input  logic                          esf_mode,
    input  logic [NUM_SLOTS-1:0]          int_sig_en,
    input  logic [NUM_SLOTS*SIG_BITS-1:0] int_sig_abcd,
    input  logic [NUM_SLOTS-1:0]          clear_mask,
    input  logic                          force_ones_clear,
    input  logic [NUM_SLOTS-1:0]          idle_mask,
    input  logic                          idle_keep_sig,
    input  logic [SLOT_BITS-1:0]          idle_code,
    output logic                          data_out,
    output logic                          fsync_out
);

    typedef struct packed {
        logic data;
        logic fs;
    } out_t;

    logic                  cur_is_f;
    logic [SLOT_W-1:0]     cur_slot;
    logic [BIT_W-1:0]      cur_bit;
    logic [FRAME_W-1:0]    cur_frame;
    abcd_t [NUM_SLOTS-1:0] shadow_w, active_w, int_arr;
    logic                  next_bit;
    out_t                  out_d, out_q;

    assign int_arr = int_sig_abcd;

    t1rb_position #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .frame_idx (frame_idx),
        .cur_is_f  (cur_is_f),
        .cur_slot  (cur_slot),
        .cur_bit   (cur_bit),
        .cur_frame (cur_frame)
    );

    t1rb_sig_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .cur_is_f  (cur_is_f),
        .cur_slot  (cur_slot),
        .cur_bit   (cur_bit),
        .cur_frame (cur_frame),
        .esf_mode  (esf_mode),
        .sig_in    (sig_in),
        .shadow    (shadow_w),
        .active    (active_w)
    );

    t1rb_bit_select #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_sel (
        .data_in          (data_in),
        .sig_in           (sig_in),
        .cur_is_f         (cur_is_f),
        .cur_slot         (cur_slot),
        .cur_bit          (cur_bit),
        .cur_frame        (cur_frame),
        .esf_mode         (esf_mode),
        .active           (active_w),
        .int_sig_en       (int_sig_en),
        .int_sig          (int_arr),
        .clear_mask       (clear_mask),
        .force_ones_clear (force_ones_clear),
        .idle_mask        (idle_mask),
        .idle_keep_sig    (idle_keep_sig),
        .idle_code        (idle_code),
        .bit_out          (next_bit)
    );

    always_comb begin
        out_d.data = next_bit;
        out_d.fs   = fsync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_out  = out_q.data;
    assign fsync_out = out_q.fs;

endmodule

// File: rtl/t1rb_inserter_chk.sv
module t1rb_inserter_chk
    import t1rb_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int SLOT_BITS = 8,
    localparam int BIT_W     = $clog2(SLOT_BITS),
    localparam int SIG_FIRST = SLOT_BITS - SIG_BITS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fsync,
    input logic [4:0]            frame_idx,
    input logic                  sig_in,
    input logic                  data_out,
    input logic                  fsync_out,
    input logic                  cur_is_f,
    input logic [BIT_W-1:0]      cur_bit,
    input logic [NUM_SLOTS-1:0]  idle_mask,
    input logic                  idle_keep_sig,
    input logic [SLOT_BITS-1:0]  idle_code,
    input abcd_t [NUM_SLOTS-1:0] shadow_w,
    input abcd_t [NUM_SLOTS-1:0] active_w
);

    logic [SLOT_BITS-1:0] idle_sh;
    logic                 mf_start;
    logic                 no_capture;
    logic                 all_idle_fill;

    assign idle_sh       = idle_code << cur_bit;
    assign mf_start      = fsync && (frame_idx == 5'd0);
    assign no_capture    = cur_is_f || (cur_bit < BIT_W'(SIG_FIRST));
    assign all_idle_fill = !cur_is_f && (&idle_mask) && !idle_keep_sig;

    // R2
    fsync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fsync_out == $past(fsync)));

    // R4
    fbit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fsync)) |-> (data_out == $past(sig_in)));

    // R6
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mf_start)) |-> $stable(active_w));

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(no_capture)) |-> $stable(shadow_w));

    // R9
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(all_idle_fill) && !$past(fsync)) |->
            (data_out == $past(idle_sh[SLOT_BITS-1])));

endmodule

bind t1rb_inserter t1rb_inserter_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fsync         (fsync),
    .frame_idx     (frame_idx),
    .sig_in        (sig_in),
    .data_out      (data_out),
    .fsync_out     (fsync_out),
    .cur_is_f      (cur_is_f),
    .cur_bit       (cur_bit),
    .idle_mask     (idle_mask),
    .idle_keep_sig (idle_keep_sig),
    .idle_code     (idle_code),
    .shadow_w      (shadow_w),
    .active_w      (active_w)
);

// File: tb/test_t1rb_inserter.sv
module test_t1rb_inserter;

    localparam int NS = 4;
    localparam int SB = 8;
    localparam int FB = 1 + NS * SB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fsync = 1'b0;
    logic [4:0]      frame_idx = '0;
    logic            data_in = 1'b0;
    logic            sig_in = 1'b0;
    logic            esf_mode = 1'b0;
    logic [NS-1:0]   int_sig_en = '0;
    logic [NS*4-1:0] int_sig_abcd = '0;
    logic [NS-1:0]   clear_mask = '0;
    logic            force_ones_clear = 1'b0;
    logic [NS-1:0]   idle_mask = '0;
    logic            idle_keep_sig = 1'b0;
    logic [SB-1:0]   idle_code = '0;
    logic            data_out;
    logic            fsync_out;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [31:0] seed = 32'h1d2c_3b4a;

    logic [3:0] shd [NS];
    logic [3:0] act [NS];
    logic       have_prev = 1'b0;
    logic       exp_bit, exp_fs;
    string      exp_tag;

    always #2 clk = ~clk;

    t1rb_inserter #(.NUM_SLOTS(NS), .SLOT_BITS(SB)) i_t1rb_inserter (
        .clk              (clk),
        .rst_n            (rst_n),
        .fsync            (fsync),
        .frame_idx        (frame_idx),
        .data_in          (data_in),
        .sig_in           (sig_in),
        .esf_mode         (esf_mode),
        .int_sig_en       (int_sig_en),
        .int_sig_abcd     (int_sig_abcd),
        .clear_mask       (clear_mask),
        .force_ones_clear (force_ones_clear),
        .idle_mask        (idle_mask),
        .idle_keep_sig    (idle_keep_sig),
        .idle_code        (idle_code),
        .data_out         (data_out),
        .fsync_out        (fsync_out)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string tag, input logic act_v, input logic exp_v);
        n_vec++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // one bit position p of frame fr; called at a falling edge
    task automatic step(input int fr, input int p);
        logic d, s, idle, base;
        int   slot, b, sel;
        bit   sigf;
        if (have_prev) begin
            check(exp_tag, data_out, exp_bit);
            check("R2 fsync_out", fsync_out, exp_fs);
        end
        seed = nxt(seed);
        d = seed[3];
        s = seed[11];
        fsync     = (p == 0);
        frame_idx = 5'(fr);
        data_in   = d;
        sig_in    = s;
        exp_fs    = (p == 0);
        if (p == 0) begin
            if (fr == 0) for (int i = 0; i < NS; i++) act[i] = shd[i];
            exp_bit = s;
            exp_tag = "R4 framing bit";
        end else begin
            slot = (p - 1) / SB;
            b    = (p - 1) % SB;
            idle = idle_mask[slot];
            base = idle ? idle_code[SB-1-b] : d;
            exp_bit = base;
            exp_tag = idle ? "R9 idle code" : "R3 pass-through";
            sigf = 1'b0;
            sel  = 0;
            if (esf_mode) begin
                if (fr % 6 == 5) begin sigf = 1'b1; sel = fr / 6; end
            end else begin
                if (fr == 5)  begin sigf = 1'b1; sel = 0; end
                if (fr == 11) begin sigf = 1'b1; sel = 1; end
            end
            if (sigf && b == SB - 1 && (!idle || idle_keep_sig)) begin
                if (clear_mask[slot]) begin
                    exp_bit = force_ones_clear ? 1'b1 : base;
                    exp_tag = idle ? "R10 R8 clear in idle" : "R8 clear channel";
                end else if (int_sig_en[slot]) begin
                    exp_bit = int_sig_abcd[slot*4 + 3 - sel];
                    exp_tag = idle ? "R10 R7 internal in idle" : "R7 internal signaling";
                end else begin
                    exp_bit = act[slot][3-sel];
                    exp_tag = idle ? "R10 R6 external in idle" : "R5 R6 external signaling";
                end
            end
            if (((esf_mode && fr == 23) || (!esf_mode && fr == 11)) && b >= SB - 4)
                shd[slot][3-(b-(SB-4))] = s;
        end
        have_prev = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int nfr;
        for (int i = 0; i < NS; i++) begin shd[i] = '0; act[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1 reset data_out", data_out, 1'b0);
        check("R1 reset fsync_out", fsync_out, 1'b0);
        rst_n = 1'b1;
        for (int mf = 0; mf < 14; mf++) begin
            seed = nxt(seed);
            esf_mode         = (mf % 3) != 0;
            clear_mask       = (mf < 2) ? '0 : NS'(seed[7:4]);
            force_ones_clear = seed[8];
            idle_mask        = (mf < 3) ? '0 : NS'(seed[15:12]);
            idle_keep_sig    = seed[16];
            idle_code        = seed[31:24];
            int_sig_en       = (mf < 4) ? '0 : NS'(seed[20:17]);
            seed = nxt(seed);
            int_sig_abcd     = seed[NS*4-1:0];
            if (mf == 13) idle_mask = '1;
            nfr = esf_mode ? 24 : 12;
            for (int f = 0; f < nfr; f++)
                for (int p = 0; p < FB; p++)
                    step(f, p);
        end
        check(exp_tag, data_out, exp_bit);
        check("R2 fsync_out", fsync_out, exp_fs);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule